// File: doc/BRIEF.md
# Five-Channel Down-Counting PWM Timer Bank

This block holds five 16-bit timers that count down at a programmable tick rate. Each tick is made in two stages. A prescaler is shared by a group of channels: channels 0 and 1 use one, and channels 2 to 4 use the other. A per-channel power-of-two divider follows the prescaler. Software programs a count buffer and a compare buffer for each channel. It then pulses a per-channel load bit, which copies the buffers into the live counter and the live compare register. After that it sets the run bit, and the counter decrements on every tick.

Channels 0 to 3 each drive a pin. After a reload the channel level starts low. The level goes high on the first decrement that makes the counter equal to the compare value, and it stays high until the next reload. An optional inversion is applied to the level. Channel 4 is an interval timer only: it has no compare stage and no pin. Every channel gives a single-cycle interrupt pulse when its counter reaches zero. When the repeat bit is set, the counter then reloads from its buffer on the next tick; otherwise it stays at zero.

A flat word-addressed register port handles writes and combinational reads. The live counters can be read at their own addresses.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every register reads 0, all pins are low and no interrupt is pending.
- R2: Address map: 0 holds the prescalers (bits [7:0] for channels 0 and 1, bits [15:8] for channels 2 to 4). 1 holds the divider codes (4 bits per channel at bit channel×4). 2 is the control word. 3 to 7 are the count buffers of channels 0 to 4. 8 to 11 are the compare buffers of channels 0 to 3. 12 to 16 are the read-only live counters of channels 0 to 4. A written register reads back its value.
- R3: One channel tick lasts (prescaler+1)×2^code clock cycles. Codes 0 to 4 divide by 1, 2, 4, 8 and 16, and any code above 4 divides by 16.
- R4: Control word layout: channel 0 uses bits [3:0], and channel k≥1 uses bits starting at (k+1)×4. Within a group the bit order is run, load, invert, repeat. Channel 4 run is bit 20.
- R5: While a channel's load bit is set, its live counter and live compare register follow the buffers each cycle, and its level is cleared.
- R6: With repeat and run set, and a count buffer value of N, the interrupt pulses once every (N+1) ticks. Each pulse lasts exactly one cycle.
- R7: With compare value C below N, the pin is high for (C+1) ticks in every period. With C equal to N, the pin never goes high.
- R8: The invert bit XORs the level of a running channel, so the pin is high for N−C ticks per period.
- R9: With repeat clear, the counter counts down once, raises one interrupt and then holds 0.
- R10: Clearing the run bit freezes the live counter, and the pin is low while the channel is stopped.
- R11: A write to a count buffer does not change the running period. The new value takes effect at the next reload.
- R12: Channel 4 uses the second prescaler and its own divider, and it produces interrupts without a compare stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 32 | Read data (combinational) |
| pwm_out | output | 4 | Pins of channels 0 to 3 |
| irq | output | 5 | Per-channel reach-zero pulses |

## Verification
The bench builds the block with its default parameters: five channels, 16-bit counters, 8-bit prescalers and 32-bit data. It programs small prescaler, divider and count values, so that each channel's period falls between 10 and 144 cycles. With these settings, several whole periods of every channel fit in a short run, together with the out-of-range divider code and the compare-equals-count case. Interrupt spacing and pin high time are measured over whole periods. This makes the checks independent of the free-running phase of the prescalers.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  // Per-channel control nibble, bit 0 = run ... bit 3 = repeat
  typedef struct packed {
    logic repeat_en;
    logic invert;
    logic load;
    logic run;
  } ch_ctl_t;

  // Bit position of a channel's control nibble in the control word
  function automatic int ctl_base(input int ch);
    return (ch == 0) ? 0 : (ch + 1) * 4;
  endfunction

  // Which shared prescaler a channel uses
  function automatic int psc_group(input int ch);
    return (ch < 2) ? 0 : 1;
  endfunction

  // Terminal value of the divider counter for a code; codes above 4 clamp
  function automatic logic [3:0] div_limit(input logic [3:0] code);
    logic [3:0] lim;
    case (code)
      4'd0:    lim = 4'd0;
      4'd1:    lim = 4'd1;
      4'd2:    lim = 4'd3;
      4'd3:    lim = 4'd7;
      default: lim = 4'd15;
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] pcnt_q;

  assign tick_o = (pcnt_q >= psc_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt_q <= '0;
    else if (tick_o) pcnt_q <= '0;
    else             pcnt_q <= pcnt_q + 1'b1;
  end

  // R3: a nonzero prescale value never gives back-to-back ticks
  a_r3_psc_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && psc_i != '0) |=> (!tick_o || psc_i == '0));
endmodule

// File: rtl/pwm_divider.sv
module pwm_divider
  import pwm_tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ptick_i,
  input  logic [3:0] code_i,
  output logic       tick_o
);
  logic [3:0] dcnt_q;
  logic [3:0] lim;

  assign lim    = div_limit(code_i);
  assign tick_o = ptick_i && (dcnt_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dcnt_q <= '0;
    else if (tick_o)  dcnt_q <= '0;
    else if (ptick_i) dcnt_q <= dcnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter bit HAS_CMP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  ch_ctl_t          ctl_i,
  input  logic [CNT_W-1:0] cbuf_i,
  input  logic [CNT_W-1:0] cmpb_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             lvl_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q;
  logic             irq_q;
  logic             step;      // a decrement happens this cycle
  logic             at_zero;
  logic             hit;       // post-decrement compare match

  assign step    = ctl_i.run && tick_i && !ctl_i.load;
  assign at_zero = (cnt_q == '0);

  if (HAS_CMP) begin : g_cmp
    logic [CNT_W-1:0] cmp_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               cmp_q <= '0;
      else if (ctl_i.load)                      cmp_q <= cmpb_i;
      else if (step && at_zero && ctl_i.repeat_en) cmp_q <= cmpb_i;
    end
    assign hit = ((cnt_q - ONE) == cmp_q);
  end else begin : g_nocmp
    logic unused_cmpb;
    assign unused_cmpb = ^cmpb_i;
    assign hit = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (ctl_i.load) begin
        cnt_q <= cbuf_i;
        lvl_q <= 1'b0;
      end else if (step) begin
        if (at_zero) begin
          if (ctl_i.repeat_en) begin
            cnt_q <= cbuf_i;
            lvl_q <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q - ONE;
          if (hit)          lvl_q <= 1'b1;
          if (cnt_q == ONE) irq_q <= 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign lvl_o = lvl_q;
  assign irq_o = irq_q;

  // R5: load copies the count buffer
  a_r5_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_i.load |=> cnt_q == $past(cbuf_i));
  // R10: stopped channel holds its counter
  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_i.run && !ctl_i.load) |=> cnt_q == $past(cnt_q));
  // R9: one-shot stays at zero
  a_r9_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && !ctl_i.repeat_en && !ctl_i.load) |=> at_zero);
  // R7: level only rises right after a decrement
  a_r7_rise_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl_q) |-> $past(tick_i && ctl_i.run && !ctl_i.load));
  // R6: interrupt lasts one cycle
  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import pwm_tmr_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CH-2:0] pwm_out,
  output logic [NUM_CH-1:0] irq
);
  localparam int NUM_PIN   = NUM_CH - 1;
  localparam int NUM_GRP   = 2;
  localparam int CFG0_W    = NUM_GRP * PSC_W;
  localparam int CFG1_W    = NUM_CH * 4;
  localparam int CTRL_W    = (NUM_CH + 1) * 4;
  localparam int A_CFG0    = 0;
  localparam int A_CFG1    = 1;
  localparam int A_CTRL    = 2;
  localparam int CBUF_BASE = 3;
  localparam int CMPB_BASE = CBUF_BASE + NUM_CH;
  localparam int LIVE_BASE = CMPB_BASE + NUM_PIN;

  logic [CFG0_W-1:0] cfg0_q;
  logic [CFG1_W-1:0] cfg1_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cbuf_q [NUM_CH];
  logic [CNT_W-1:0]  cmpb_q [NUM_PIN];
  logic [CNT_W-1:0]  live_w [NUM_CH];
  logic [NUM_GRP-1:0] grp_tick;
  logic [NUM_CH-1:0]  ch_tick;

  // Register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0_q <= '0;
      cfg1_q <= '0;
      ctrl_q <= '0;
      for (int i = 0; i < NUM_CH; i++)  cbuf_q[i] <= '0;
      for (int i = 0; i < NUM_PIN; i++) cmpb_q[i] <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_CFG0)) cfg0_q <= wr_data[CFG0_W-1:0];
      if (wr_addr == ADDR_W'(A_CFG1)) cfg1_q <= wr_data[CFG1_W-1:0];
      if (wr_addr == ADDR_W'(A_CTRL)) ctrl_q <= wr_data[CTRL_W-1:0];
      for (int i = 0; i < NUM_CH; i++)
        if (wr_addr == ADDR_W'(CBUF_BASE + i)) cbuf_q[i] <= wr_data[CNT_W-1:0];
      for (int i = 0; i < NUM_PIN; i++)
        if (wr_addr == ADDR_W'(CMPB_BASE + i)) cmpb_q[i] <= wr_data[CNT_W-1:0];
    end
  end

  // Combinational read
  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(A_CFG0)) rd_data = DATA_W'(cfg0_q);
    if (rd_addr == ADDR_W'(A_CFG1)) rd_data = DATA_W'(cfg1_q);
    if (rd_addr == ADDR_W'(A_CTRL)) rd_data = DATA_W'(ctrl_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_addr == ADDR_W'(CBUF_BASE + i)) rd_data = DATA_W'(cbuf_q[i]);
      if (rd_addr == ADDR_W'(LIVE_BASE + i)) rd_data = DATA_W'(live_w[i]);
    end
    for (int i = 0; i < NUM_PIN; i++)
      if (rd_addr == ADDR_W'(CMPB_BASE + i)) rd_data = DATA_W'(cmpb_q[i]);
  end

  // Shared prescalers
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_psc
    pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .psc_i  (cfg0_q[g*PSC_W +: PSC_W]),
      .tick_o (grp_tick[g])
    );
  end

  // Channels
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int GRP  = psc_group(c);
    localparam int BASE = ctl_base(c);
    localparam bit PIN  = (c < NUM_PIN);

    ch_ctl_t          ctl;
    logic             ch_lvl;
    logic [CNT_W-1:0] cmpb_in;

    assign ctl = ch_ctl_t'(ctrl_q[BASE +: 4]);

    pwm_divider u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .ptick_i (grp_tick[GRP]),
      .code_i  (cfg1_q[c*4 +: 4]),
      .tick_o  (ch_tick[c])
    );

    if (PIN) begin : g_pin
      assign cmpb_in = cmpb_q[c];
      assign pwm_out[c] = ctl.run & (ch_lvl ^ ctl.invert);
    end else begin : g_nopin
      logic unused_lvl;
      assign cmpb_in    = '0;
      assign unused_lvl = ch_lvl;
    end

    pwm_channel #(.CNT_W(CNT_W), .HAS_CMP(PIN)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (ch_tick[c]),
      .ctl_i  (ctl),
      .cbuf_i (cbuf_q[c]),
      .cmpb_i (cmpb_in),
      .cnt_o  (live_w[c]),
      .lvl_o  (ch_lvl),
      .irq_o  (irq[c])
    );

    // R3: a channel tick only comes with its own group's prescaler tick
    a_r3_tick_in_group: assert property (@(posedge clk) disable iff (!rst_n)
      ch_tick[c] |-> grp_tick[GRP]);
  end

  // Unused control nibble (bits 7:4) is held as plain storage
  logic unused_ctrl;
  assign unused_ctrl = ^ctrl_q[7:4];
endmodule

// File: tb/pwm_timer_bank_tb.sv
`timescale 1ns/1ps
module pwm_timer_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  pwm_out;
  logic [4:0]  irq;

  pwm_timer_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pwm_out(pwm_out), .irq(irq)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_irq [5];
  int irq_cnt  [5];
  int exp_q [5][$];   // scoreboard: expected irq spacing per channel
  logic [31:0] ctl_shadow = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops expectations as interrupts arrive
  initial begin
    for (int i = 0; i < 5; i++) begin last_irq[i] = -1; irq_cnt[i] = 0; end
    forever begin
      @(negedge clk);
      for (int i = 0; i < 5; i++) begin
        if (irq[i]) begin
          irq_cnt[i]++;
          if (last_irq[i] >= 0 && exp_q[i].size() > 0) begin
            int e;
            e = exp_q[i].pop_front();
            chk((cyc - last_irq[i]) == e, $sformatf("R6 irq spacing ch%0d", i),
                cyc - last_irq[i], e);
          end
          last_irq[i] = cyc;
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = 5'(a);
    #1 d = rd_data;
  endtask

  function automatic logic [31:0] ctl_bits(input int ch, input bit run, input bit ld,
                                           input bit inv, input bit rep);
    int b;
    b = (ch == 0) ? 0 : (ch + 1) * 4;
    return (32'(run) << b) | (32'(ld) << (b + 1)) | (32'(inv) << (b + 2)) |
           (32'(rep) << (b + 3));
  endfunction

  function automatic logic [31:0] ctl_mask(input int ch);
    return 32'hF << ((ch == 0) ? 0 : (ch + 1) * 4);
  endfunction

  task automatic set_ctl(input int ch, input bit run, input bit ld, input bit inv, input bit rep);
    ctl_shadow = (ctl_shadow & ~ctl_mask(ch)) | ctl_bits(ch, run, ld, inv, rep);
    wr(2, ctl_shadow);
  endtask

  // Driver side of the scoreboard
  task automatic expect_spacing(input int ch, input int iv, input int n);
    @(posedge clk);
    last_irq[ch] = -1;
    for (int k = 0; k < n; k++) exp_q[ch].push_back(iv);
    for (int t = 0; t < iv * (n + 2) && exp_q[ch].size() > 0; t++) @(negedge clk);
    chk(exp_q[ch].size() == 0, $sformatf("R6 spacing timeout ch%0d", ch), exp_q[ch].size(), 0);
    exp_q[ch].delete();
  endtask

  task automatic wait_irq(input int ch, input int limit, output int at);
    at = -1;
    for (int t = 0; t < limit; t++) begin
      @(negedge clk);
      if (irq[ch]) begin at = cyc; break; end
    end
    chk(at >= 0, $sformatf("R6 irq timeout ch%0d", ch), at, 0);
  endtask

  task automatic duty(input int ch, input int period, input int exp_high, input string tag);
    int at, hi;
    wait_irq(ch, period * 2, at);
    hi = 0;
    for (int t = 0; t < period; t++) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
    chk(hi == exp_high, tag, hi, exp_high);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int a, b, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    c0 = 0;
    for (int i = 0; i <= 16; i++) begin
      rd(i, v);
      if (v != 0) c0++;
    end
    chk(c0 == 0, "R1 registers zero after reset", c0, 0);
    chk(pwm_out == 4'h0 && irq == 5'h0, "R1 outputs low", {pwm_out, irq}, 0);

    // R2/R3: prescalers 1 (group 0) and 2 (group 1); codes ch0..4 = 1,0,2,7,0
    wr(0, 32'h0000_0201);
    wr(1, 32'h0000_7201);
    rd(0, v); chk(v == 32'h201, "R2 prescaler readback", v, 32'h201);
    rd(1, v); chk(v == 32'h7201, "R2 divider readback", v, 32'h7201);
    wr(3, 9);  wr(8, 3);
    wr(4, 4);  wr(9, 4);
    wr(5, 5);  wr(10, 1);
    wr(6, 2);  wr(11, 0);
    wr(7, 7);
    rd(5, v);  chk(v == 5, "R2 count buffer readback", v, 5);
    rd(10, v); chk(v == 1, "R2 compare buffer readback", v, 1);

    // R5: load bits held, live counters follow buffers; R4 load bit positions
    for (int i = 0; i < 5; i++) ctl_shadow |= ctl_bits(i, 0, 1, 0, 0);
    wr(2, ctl_shadow);
    rd(12, v); chk(v == 9, "R5 live ch0 after load", v, 9);
    rd(16, v); chk(v == 7, "R5 live ch4 after load", v, 7);
    chk(pwm_out == 4'h0, "R10 pins low while stopped", pwm_out, 0);

    // R4: run + repeat for all channels (ch4 run at bit 20)
    ctl_shadow = '0;
    for (int i = 0; i < 5; i++) ctl_shadow |= ctl_bits(i, 1, 0, 0, 1);
    wr(2, ctl_shadow);
    chk(ctl_shadow[20] == 1'b1, "R4 ch4 run bit position", ctl_shadow[20], 1);

    // R3/R6/R12: spacing = (N+1)*(psc+1)*2^code
    expect_spacing(0, 40, 2);   // R3 T=4, N=9
    expect_spacing(1, 10, 2);   // T=2, N=4
    expect_spacing(2, 72, 2);   // T=12, N=5
    expect_spacing(3, 144, 2);  // R3 code 7 clamps to 16: T=48, N=2
    expect_spacing(4, 24, 2);   // R12 T=3, N=7

    // R7: high time (C+1)*T
    duty(0, 40, 16, "R7 ch0 high time");
    duty(1, 10, 0, "R7 compare equal to count never high");
    duty(2, 72, 24, "R7 ch2 high time");
    duty(3, 144, 48, "R7 ch3 compare zero");

    // R8: invert
    set_ctl(0, 1, 0, 1, 1);
    duty(0, 40, 24, "R8 inverted high time");
    set_ctl(0, 1, 0, 0, 1);

    // R11: buffer write mid-period does not change the current period
    wait_irq(0, 100, a);
    repeat (12) @(negedge clk);
    wr(3, 4);
    wait_irq(0, 100, b);
    chk(b - a == 40, "R11 period unchanged after buffer write", b - a, 40);
    wait_irq(0, 100, a);
    chk(a - b == 20, "R11 new count used after reload", a - b, 20);

    // R10: stop freezes counter and forces pin low
    set_ctl(2, 0, 0, 0, 1);
    rd(14, v);
    c0 = 0;
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      if (pwm_out[2]) c0++;
    end
    rd(14, v2);
    chk(v == v2, "R10 counter frozen", v2, v);
    chk(c0 == 0, "R10 pin low when stopped", c0, 0);

    // R9: one-shot
    set_ctl(1, 0, 1, 0, 0);
    set_ctl(1, 0, 0, 0, 0);
    rd(13, v); chk(v == 4, "R5 ch1 reloaded", v, 4);
    irq_cnt[1] = 0;
    set_ctl(1, 1, 0, 0, 0);
    repeat (100) @(negedge clk);
    chk(irq_cnt[1] == 1, "R9 single interrupt", irq_cnt[1], 1);
    rd(13, v); chk(v == 0, "R9 counter holds zero", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule